// File: doc/BRIEF.md
# Nine-bit Replay FIFO with Half-Full Status

This block is a first-in/first-out word buffer nine bits wide, so each byte can carry a parity or control bit alongside it. Its depth is a power-of-two parameter between 256 and 8,192 words. Words enter and leave through internal circular write and read pointers, so no address is ever supplied. Writers and readers use separate active-low strobes, and the two sides may act in the same cycle. The strobes, the data input and the retransmit pin are all sampled on one free-running clock.

A write takes effect on the rising edge of the write strobe. While the read strobe is held low, the word at the head of the buffer is driven on the output. The read pointer advances when the read strobe rises. When no read is in progress, the output is released to high impedance. Active-low flags report empty, full and more-than-half-full. A write is dropped when the buffer is full, and a read is dropped when it is empty.

A mode input selects how two dual-purpose pins behave. In single-device mode, the first pin is a retransmit request: it rewinds the read pointer to the first stored word so the data can be replayed. The second pin is then the half-full flag. In depth-expansion mode, the first pin is a first-load input and the block takes no action on it. The second pin then carries a one-cycle expansion-out pulse, which marks when the last storage location is written or read.

Top module: `fifo9_replay`

## Requirements
- R1: Words are returned in the order they were written. All nine bits are kept, including bit 8.
- R2: A write stores the `din` value present when `wr_n` rises. Holding `wr_n` low or high stores nothing more.
- R3: While `rd_n` is low, `q` carries the head word. The read pointer advances once when `rd_n` rises.
- R4: `full_n` is low exactly when DEPTH words are stored. A write while full is dropped and does not overwrite stored data.
- R5: `empty_n` is low exactly when no word is stored. A read while empty is dropped, and the read pointer does not move.
- R6: With `depth_exp` = 0, `xo_hf_n` is low when more than DEPTH/2 words are stored. It is high when DEPTH/2 or fewer words are stored.
- R7: With `depth_exp` = 0, holding `rt_fl_n` low returns the read pointer to the first location and leaves the write pointer unchanged. The occupancy becomes the number of words written since reset, which must be at most DEPTH.
- R8: With `depth_exp` = 1, `rt_fl_n` has no effect. `xo_hf_n` ignores the fill level and pulses low for one clock after the last location (DEPTH-1) is written or read.
- R9: Reset sets `empty_n` low, `full_n` high and `xo_hf_n` high, and discards all stored words.
- R10: A read and a write whose strobes rise in the same cycle both take effect, and the occupancy does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| depth_exp | input | 1 | 0: single-device mode, 1: depth-expansion mode |
| wr_n | input | 1 | Active-low write strobe; a write completes on its rising edge |
| din | input | 9 | Write data |
| rd_n | input | 1 | Active-low read strobe |
| rt_fl_n | input | 1 | Retransmit request (mode 0) or first-load input (mode 1), active low |
| q | output | 9 | Read data, high impedance while no read is active |
| empty_n | output | 1 | Low when the buffer is empty |
| full_n | output | 1 | Low when the buffer is full |
| xo_hf_n | output | 1 | Half-full flag (mode 0) or expansion-out pulse (mode 1), active low |

## Verification
The hardest state to reach is a retransmit issued from a full buffer after part of the data has already been read out. At that moment the read pointer sits in mid-range and the occupancy must jump back up to the full depth. The stimulus first fills every location, then performs one write that must be dropped, then reads a few words. It then pulls the retransmit pin low and replays the whole depth, checking every word and the moment the half-full flag releases. Depth-expansion mode uses the same full-depth walk, and it counts the expansion-out pulses on both the write and the read side of the last location.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
  localparam int WORD_W = 9;

  typedef enum logic {
    MODE_SINGLE    = 1'b0,
    MODE_DEPTH_EXP = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/fifo9_rst_sync.sv
module fifo9_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/fifo9_strobe.sv
module fifo9_strobe #(
  parameter int NUM = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] pin_n,
  output logic [NUM-1:0] level_n,
  output logic [NUM-1:0] rise
);
  for (genvar g = 0; g < NUM; g++) begin : g_strobe
    logic cur_q, prev_q;
    logic cur_d, prev_d;

    always_comb begin
      cur_d  = pin_n[g];
      prev_d = cur_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q  <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        cur_q  <= cur_d;
        prev_q <= prev_d;
      end
    end

    assign level_n[g] = cur_q;
    assign rise[g]    = cur_q & ~prev_q;
  end
endmodule

// File: rtl/fifo9_ram.sv
module fifo9_ram #(
  parameter int DEPTH = 256,
  parameter int W     = fifo9_pkg::WORD_W,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fifo9_ctrl.sv
module fifo9_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_exp,
  input  logic          wr_rise,
  input  logic          rd_rise,
  input  logic          rt_req,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count,
  output logic          xo_pulse
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_LOC = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d, total_q, total_d;
  logic          xo_q, xo_d;
  logic          wr_ok, rd_ok, rt_act;

  always_comb begin
    rt_act   = rt_req & ~mode_exp;
    wr_ok    = wr_rise & (cnt_q != FULL_CNT);
    rd_ok    = rd_rise & (cnt_q != '0) & ~rt_act;
    wr_ptr_d = wr_ok ? wr_ptr_q + 1'b1 : wr_ptr_q;
    total_d  = (wr_ok && total_q != FULL_CNT) ? total_q + 1'b1 : total_q;
    if (rt_act)     rd_ptr_d = '0;
    else if (rd_ok) rd_ptr_d = rd_ptr_q + 1'b1;
    else            rd_ptr_d = rd_ptr_q;
    if (rt_act) cnt_d = total_d;
    else        cnt_d = cnt_q + CW'(wr_ok) - CW'(rd_ok);
    xo_d = mode_exp & ((wr_ok & (wr_ptr_q == LAST_LOC)) |
                       (rd_ok & (rd_ptr_q == LAST_LOC)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      total_q  <= '0;
      xo_q     <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      total_q  <= total_d;
      xo_q     <= xo_d;
    end
  end

  assign we       = wr_ok;
  assign waddr    = wr_ptr_q;
  assign raddr    = rd_ptr_q;
  assign count    = cnt_q;
  assign xo_pulse = xo_q;
endmodule

// File: rtl/fifo9_replay.sv
module fifo9_replay #(
  parameter int DEPTH = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       depth_exp,
  input  logic       wr_n,
  input  logic [8:0] din,
  input  logic       rd_n,
  input  logic       rt_fl_n,
  output logic [8:0] q,
  output logic       empty_n,
  output logic       full_n,
  output logic       xo_hf_n
);
  import fifo9_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic          rst_sync_n;
  logic [2:0]    lvl_n, rise;
  logic [8:0]    din_q, din_d;
  logic          we, xo_pulse;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] count;
  logic [8:0]    rdata;
  fifo_mode_e    mode;

  assign mode = fifo_mode_e'(depth_exp);

  fifo9_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fifo9_strobe #(.NUM(3)) u_strobe (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pin_n   ({rt_fl_n, rd_n, wr_n}),
    .level_n (lvl_n),
    .rise    (rise)
  );

  always_comb din_d = din;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) din_q <= '0;
    else             din_q <= din_d;
  end

  fifo9_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mode_exp (mode == MODE_DEPTH_EXP),
    .wr_rise  (rise[0]),
    .rd_rise  (rise[1]),
    .rt_req   (~lvl_n[2]),
    .we       (we),
    .waddr    (waddr),
    .raddr    (raddr),
    .count    (count),
    .xo_pulse (xo_pulse)
  );

  fifo9_ram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (din_q),
    .raddr (raddr),
    .rdata (rdata)
  );

  assign q       = lvl_n[1] ? 'z : rdata;
  assign empty_n = (count != '0);
  assign full_n  = (count != FULL_CNT);
  assign xo_hf_n = (mode == MODE_DEPTH_EXP) ? ~xo_pulse : ~(count > HALF_CNT);
endmodule

// File: rtl/fifo9_replay_chk.sv
module fifo9_replay_chk (
  input logic clk,
  input logic rst_sync_n,
  input logic depth_exp,
  input logic empty_n,
  input logic full_n,
  input logic xo_hf_n
);
  AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(!full_n && !empty_n));                                          // R4
  AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!depth_exp && !full_n) |-> !xo_hf_n);                            // R6
  AST_EMPTY_NOT_HALF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!depth_exp && !empty_n) |-> xo_hf_n);                            // R6
  AST_EXP_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (depth_exp && !empty_n && $past(!empty_n) && $past(depth_exp)) |-> xo_hf_n); // R8
  AST_RESET_FLAGS: assert property (@(posedge clk)
    !rst_sync_n |-> (!empty_n && full_n));                            // R9
endmodule

bind fifo9_replay fifo9_replay_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .depth_exp  (depth_exp),
  .empty_n    (empty_n),
  .full_n     (full_n),
  .xo_hf_n    (xo_hf_n)
);

// File: tb/test_fifo9_replay.sv
module test_fifo9_replay;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n, depth_exp, wr_n, rd_n, rt_fl_n;
  logic [8:0] din;
  wire  [8:0] q;
  logic       empty_n, full_n, xo_hf_n;

  int checks = 0;
  int fails  = 0;
  int xo_cnt = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fifo9_replay #(.DEPTH(DEPTH)) i_fifo9_replay (
    .clk(clk), .rst_n(rst_n), .depth_exp(depth_exp), .wr_n(wr_n), .din(din),
    .rd_n(rd_n), .rt_fl_n(rt_fl_n), .q(q), .empty_n(empty_n), .full_n(full_n),
    .xo_hf_n(xo_hf_n)
  );

  always @(negedge clk) if (depth_exp && rst_n && xo_hf_n === 1'b0) xo_cnt++;

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 5) & 511);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [8:0] d);
    @(negedge clk); din = d; wr_n = 1'b0;
    repeat (2) @(negedge clk); wr_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(output logic [8:0] d);
    @(negedge clk); rd_n = 1'b0;
    repeat (2) @(negedge clk); d = q; rd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_both(input logic [8:0] wd, output logic [8:0] rd);
    @(negedge clk); din = wd; wr_n = 1'b0; rd_n = 1'b0;
    repeat (2) @(negedge clk); rd = q; wr_n = 1'b1; rd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_rt();
    @(negedge clk); rt_fl_n = 1'b0;
    repeat (2) @(negedge clk); rt_fl_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk); depth_exp = mode; rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // op: 0 write, 1 read, 2 read+write together, 3 read on empty
  // {op[1:0], data[8:0], expected q[8:0], expected {empty_n, full_n, xo_hf_n}}
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 9'h1A5, 9'h000, 3'b111},  // R2
    {2'd0, 9'h0FF, 9'h000, 3'b111},
    {2'd0, 9'h100, 9'h000, 3'b111},  // R1 bit 8
    {2'd1, 9'h000, 9'h1A5, 3'b111},  // R3
    {2'd2, 9'h055, 9'h0FF, 3'b111},  // R10
    {2'd1, 9'h000, 9'h100, 3'b111},
    {2'd1, 9'h000, 9'h055, 3'b011},  // R5
    {2'd3, 9'h000, 9'h000, 3'b011},  // R5 read while empty
    {2'd0, 9'h1FF, 9'h000, 3'b111},
    {2'd1, 9'h000, 9'h1FF, 3'b011}   // R5 pointer unmoved
  };

  initial begin
    logic [8:0] r;
    rst_n = 1'b1; depth_exp = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_fl_n = 1'b1; din = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 reset flags", {empty_n, full_n, xo_hf_n}, 3'b011);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      op = VEC[v][22:21];
      case (op)
        2'd0: do_write(VEC[v][20:12]);
        2'd1: begin do_read(r); chk("R1 R3 table read data", r, VEC[v][11:3]); end
        2'd2: begin do_both(VEC[v][20:12], r); chk("R10 table both data", r, VEC[v][11:3]); end
        default: do_read(r);
      endcase
      chk("R4 R5 table flags", {empty_n, full_n, xo_hf_n}, VEC[v][2:0]);
    end

    // R6 / R4 / R7 in single mode
    do_reset(1'b0);
    for (int i = 0; i < DEPTH / 2; i++) do_write(pat(i));
    chk("R6 exactly half not flagged", xo_hf_n, 1);
    do_write(pat(DEPTH / 2));
    chk("R6 above half flagged", xo_hf_n, 0);
    for (int i = DEPTH / 2 + 1; i < DEPTH; i++) do_write(pat(i));
    chk("R4 full flag", full_n, 0);
    do_write(9'h0AA);
    chk("R4 still full after dropped write", full_n, 0);
    for (int i = 0; i < 3; i++) begin
      do_read(r); chk("R1 head words", r, pat(i));
    end
    chk("R4 not full after reads", full_n, 1);
    do_rt();
    chk("R7 retransmit restores full", full_n, 0);
    for (int i = 0; i < DEPTH; i++) begin
      do_read(r);
      if (r != pat(i) || i == 0 || i == DEPTH - 1) chk("R7 replayed word", r, pat(i));
      if (i == DEPTH / 2 - 2) chk("R6 still above half", xo_hf_n, 0);
      if (i == DEPTH / 2 - 1) chk("R6 released at half", xo_hf_n, 1);
    end
    chk("R5 empty after replay", empty_n, 0);
    do_write(9'h133);
    do_read(r);
    chk("R7 write pointer kept", r, 9'h133);

    // R8 depth-expansion mode
    do_reset(1'b1);
    xo_cnt = 0;
    for (int i = 0; i < DEPTH - 1; i++) begin
      do_write(pat(i + 7));
      if (i == DEPTH - 10) chk("R8 no half flag in expansion", xo_hf_n, 1);
    end
    chk("R8 no pulse before last location", xo_cnt, 0);
    do_write(pat(DEPTH + 6));
    chk("R8 pulse on last write", xo_cnt, 1);
    do_read(r); chk("R8 first word", r, pat(7));
    do_rt();
    do_read(r); chk("R8 first-load pin ignored", r, pat(8));
    for (int i = 2; i < DEPTH; i++) do_read(r);
    chk("R8 last word", r, pat(DEPTH + 6));
    chk("R8 pulse on last read", xo_cnt, 2);
    chk("R5 empty in expansion", empty_n, 0);

    // R9 reset mid-stream
    do_reset(1'b0);
    do_write(9'h011); do_write(9'h022);
    do_reset(1'b0);
    chk("R9 reset clears words", {empty_n, full_n, xo_hf_n}, 3'b011);
    do_write(9'h044);
    do_read(r);
    chk("R9 old words discarded", r, 9'h044);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule